// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Engine

This block sits behind a redirection table and decides when each interrupt pin produces a delivery message. The raw pin levels come in every cycle. The block corrects each one by its entry's polarity bit and keeps a request bit per pin that follows the corrected level. From this it decides, per pin and per trigger mode, whether a new delivery is due. Level-triggered pins are held off by a remote-pending bit until an end-of-interrupt (EOI) for their vector arrives. A new assertion that cannot be delivered is flagged as coalesced on a per-pin pulse.

Messages leave through a valid/ready handshake, one pin at a time, lowest pin first. Each message carries the entry's destination, vector, destination mode, trigger mode and delivery type. Pin 0 is redirected to a fixed boot processor.

EOIs are accepted one at a time. An EOI starts a scan that walks the table one entry per cycle. For every entry whose vector matches, the block emits an acknowledge with that pin's index. A level-mode EOI also releases the entry's remote-pending bit and can fire the entry again. The table contents arrive on input ports, because the register access path is not part of this block.

Top module: `irq_pin_engine`

## Requirements
- R1: The effective level of a pin is its raw level XOR its polarity bit. With polarity 1, a raw low counts as an active request and a raw high counts as idle.
- R2: In edge mode (trigger bit 0), a pin requests one delivery each time its effective level goes from low to high. Holding the level high produces no further message.
- R3: An edge-mode pin that rises again while its previous request is still waiting is flagged on its bit of `coal_o`, in the same cycle as the rise. That request is dropped.
- R4: In level mode (trigger bit 1), an active pin requests delivery only while its remote-pending bit is clear. Loading its message sets that bit, so a pin held active sends exactly one message. If the pin rises again while the bit is set, the rise is flagged on `coal_o`.
- R5: A pin whose mask bit is 1 is never placed in a message.
- R6: When several pins are waiting, the lowest-numbered one is sent first, one message per accepted handshake. While `msg_valid_o` is high and `msg_ready_i` is low, the message fields do not change.
- R7: A message for pin 0 carries destination `BOOT_ID` and destination mode 0 (physical), whatever its table entry holds.
- R8: For other pins, the message copies the entry's vector, destination, destination mode, trigger bit (1 = level) and delivery type. The level flag `msg_level_o` is 1 on every message.
- R9: An accepted EOI makes `eoi_busy_o` high for exactly NPINS cycles. During the scan, entries 0 to NPINS-1 are visited in order, one per cycle. Each entry whose vector equals the EOI vector pulses `ack_valid_o` with its index on `ack_pin_o`. An EOI offered while the block is busy is ignored.
- R10: A level-mode EOI (`eoi_level_i` = 1) clears the remote-pending bit of each matching entry. If the entry is level-triggered, unmasked and still active, it is delivered again. An edge-mode EOI leaves the remote-pending bits as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_raw_i | input | NPINS | Raw interrupt pin levels |
| ent_pol_i | input | NPINS | Per-entry polarity (1 = active low) |
| ent_mask_i | input | NPINS | Per-entry mask (1 = masked) |
| ent_trig_i | input | NPINS | Per-entry trigger (1 = level, 0 = edge) |
| ent_dmode_i | input | NPINS | Per-entry destination mode (0 = physical) |
| ent_vec_i | input | NPINS*VEC_W | Per-entry vectors, pin i at bits i*VEC_W |
| ent_dest_i | input | NPINS*DEST_W | Per-entry destinations |
| ent_dlv_i | input | NPINS*DLV_W | Per-entry delivery type |
| eoi_valid_i | input | 1 | EOI offered |
| eoi_vector_i | input | VEC_W | Vector being acknowledged |
| eoi_level_i | input | 1 | EOI is for a level-mode interrupt |
| eoi_busy_o | output | 1 | EOI scan in progress |
| ack_valid_o | output | 1 | Acknowledge for a matching entry |
| ack_pin_o | output | $clog2(NPINS) | Index of the acknowledged entry |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_dest_o | output | DEST_W | Message destination |
| msg_vector_o | output | VEC_W | Message vector |
| msg_dmode_o | output | 1 | Message destination mode |
| msg_trig_o | output | 1 | Message trigger mode |
| msg_dlv_o | output | DLV_W | Message delivery type |
| msg_level_o | output | 1 | Message level flag |
| coal_o | output | NPINS | Per-pin coalesced pulse |

## Verification
The bench builds the block with NPINS = 4 and BOOT_ID = 8'h5A. With four pins, a full EOI scan takes only four cycles, so the end of the scan and the held-off second EOI can be observed within a short window. The nonzero boot identifier differs from every table destination the bench programs, so the pin 0 override is visible at the port. Two entries share one vector, which makes the ordered acknowledge sequence observable.

// File: rtl/ipe_pkg.sv
package ipe_pkg;

  typedef enum logic { TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1 } trig_e;

  localparam logic DMODE_PHYS = 1'b0;

  // corrected request level of a pin
  function automatic logic eff_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

  // index of the least significant set bit, 0 when none
  function automatic int unsigned first_set(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/ipe_pin_cell.sv
module ipe_pin_cell
  import ipe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pol_i,
  input  logic mask_i,
  input  logic trig_i,
  input  logic load_i,
  input  logic eoi_hit_i,
  input  logic eoi_lvl_i,
  output logic pend_o,
  output logic rirr_o,
  output logic coal_o
);
  logic irr_q, pend_q, rirr_q;
  logic eff, rise, lvl_req, edge_req, eoi_clr, eoi_req;

  always_comb begin
    eff      = eff_level(raw_i, pol_i);
    rise     = eff & ~irr_q;
    eoi_clr  = eoi_hit_i & eoi_lvl_i;
    lvl_req  = (trig_i == TRIG_LEVEL) & eff & ~rirr_q & ~pend_q & ~mask_i;
    edge_req = (trig_i == TRIG_EDGE) & rise & ~pend_q & ~mask_i;
    eoi_req  = eoi_clr & (trig_i == TRIG_LEVEL) & ~mask_i & irr_q & ~pend_q;
    coal_o   = rise & ((trig_i == TRIG_LEVEL) ? (rirr_q | pend_q) : pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      irr_q  <= eff;
      pend_q <= (pend_q & ~load_i) | lvl_req | edge_req | eoi_req;
      if (load_i && trig_i == TRIG_LEVEL) rirr_q <= 1'b1;
      else if (eoi_clr)                   rirr_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
endmodule

// File: rtl/ipe_eoi_scan.sv
module ipe_eoi_scan #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid_i,
  input  logic [VEC_W-1:0]       eoi_vector_i,
  input  logic                   eoi_level_i,
  input  logic [NPINS*VEC_W-1:0] ent_vec_i,
  output logic                   busy_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   lvl_o,
  output logic                   ack_o,
  output logic [NPINS-1:0]       hit_o
);
  logic             busy_q, lvl_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;
  logic             match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else if (!busy_q) begin
      if (eoi_valid_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        vec_q  <= eoi_vector_i;
        lvl_q  <= eoi_level_i;
      end
    end else if (idx_q == IDX_W'(NPINS - 1)) begin
      busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    match = busy_q && (ent_vec_i[idx_q*VEC_W +: VEC_W] == vec_q);
    hit_o = '0;
    if (match) hit_o[idx_q] = 1'b1;
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign lvl_o  = lvl_q;
  assign ack_o  = match;
endmodule

// File: rtl/ipe_msg_out.sv
module ipe_msg_out
  import ipe_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  parameter int DLV_W  = 3,
  parameter logic [DEST_W-1:0] BOOT_ID = '0,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        elig_i,
  input  logic [NPINS*VEC_W-1:0]  ent_vec_i,
  input  logic [NPINS*DEST_W-1:0] ent_dest_i,
  input  logic [NPINS*DLV_W-1:0]  ent_dlv_i,
  input  logic [NPINS-1:0]        ent_dmode_i,
  input  logic [NPINS-1:0]        ent_trig_i,
  input  logic                    ready_i,
  output logic                    valid_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [DEST_W-1:0]       dest_o,
  output logic                    dmode_o,
  output logic                    trig_o,
  output logic [DLV_W-1:0]        dlv_o,
  output logic [NPINS-1:0]        load_o
);
  logic             free, take;
  logic [IDX_W-1:0] sel;

  always_comb begin
    free   = ~valid_o | ready_i;
    take   = free & (|elig_i);
    sel    = IDX_W'(first_set(64'(elig_i)));
    load_o = '0;
    if (take) load_o[sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
      dest_o  <= '0;
      dmode_o <= 1'b0;
      trig_o  <= 1'b0;
      dlv_o   <= '0;
    end else if (take) begin
      valid_o <= 1'b1;
      vec_o   <= ent_vec_i[sel*VEC_W +: VEC_W];
      dlv_o   <= ent_dlv_i[sel*DLV_W +: DLV_W];
      trig_o  <= ent_trig_i[sel];
      if (sel == '0) begin
        dest_o  <= BOOT_ID;
        dmode_o <= DMODE_PHYS;
      end else begin
        dest_o  <= ent_dest_i[sel*DEST_W +: DEST_W];
        dmode_o <= ent_dmode_i[sel];
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine #(
  parameter int NPINS  = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  parameter int DLV_W  = 3,
  parameter logic [DEST_W-1:0] BOOT_ID = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPINS-1:0]           pin_raw_i,
  input  logic [NPINS-1:0]           ent_pol_i,
  input  logic [NPINS-1:0]           ent_mask_i,
  input  logic [NPINS-1:0]           ent_trig_i,
  input  logic [NPINS-1:0]           ent_dmode_i,
  input  logic [NPINS*VEC_W-1:0]     ent_vec_i,
  input  logic [NPINS*DEST_W-1:0]    ent_dest_i,
  input  logic [NPINS*DLV_W-1:0]     ent_dlv_i,
  input  logic                       eoi_valid_i,
  input  logic [VEC_W-1:0]           eoi_vector_i,
  input  logic                       eoi_level_i,
  output logic                       eoi_busy_o,
  output logic                       ack_valid_o,
  output logic [$clog2(NPINS)-1:0]   ack_pin_o,
  output logic                       msg_valid_o,
  input  logic                       msg_ready_i,
  output logic [DEST_W-1:0]          msg_dest_o,
  output logic [VEC_W-1:0]           msg_vector_o,
  output logic                       msg_dmode_o,
  output logic                       msg_trig_o,
  output logic [DLV_W-1:0]           msg_dlv_o,
  output logic                       msg_level_o,
  output logic [NPINS-1:0]           coal_o
);
  localparam int IDX_W = $clog2(NPINS);

  // named internal events, observed by the bound checker
  logic [NPINS-1:0] pend, rirr, elig, load_vec, eoi_hit;
  logic [IDX_W-1:0] scan_idx;
  logic             eoi_lvl;

  assign elig = pend & ~ent_mask_i;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    ipe_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (pin_raw_i[p]),
      .pol_i     (ent_pol_i[p]),
      .mask_i    (ent_mask_i[p]),
      .trig_i    (ent_trig_i[p]),
      .load_i    (load_vec[p]),
      .eoi_hit_i (eoi_hit[p]),
      .eoi_lvl_i (eoi_lvl),
      .pend_o    (pend[p]),
      .rirr_o    (rirr[p]),
      .coal_o    (coal_o[p])
    );
  end

  ipe_eoi_scan #(.NPINS(NPINS), .VEC_W(VEC_W)) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .eoi_valid_i  (eoi_valid_i),
    .eoi_vector_i (eoi_vector_i),
    .eoi_level_i  (eoi_level_i),
    .ent_vec_i    (ent_vec_i),
    .busy_o       (eoi_busy_o),
    .idx_o        (scan_idx),
    .lvl_o        (eoi_lvl),
    .ack_o        (ack_valid_o),
    .hit_o        (eoi_hit)
  );
  assign ack_pin_o = scan_idx;

  ipe_msg_out #(
    .NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .DLV_W(DLV_W), .BOOT_ID(BOOT_ID)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .elig_i      (elig),
    .ent_vec_i   (ent_vec_i),
    .ent_dest_i  (ent_dest_i),
    .ent_dlv_i   (ent_dlv_i),
    .ent_dmode_i (ent_dmode_i),
    .ent_trig_i  (ent_trig_i),
    .ready_i     (msg_ready_i),
    .valid_o     (msg_valid_o),
    .vec_o       (msg_vector_o),
    .dest_o      (msg_dest_o),
    .dmode_o     (msg_dmode_o),
    .trig_o      (msg_trig_o),
    .dlv_o       (msg_dlv_o),
    .load_o      (load_vec)
  );

  assign msg_level_o = msg_valid_o;
endmodule

// File: rtl/ipe_checker.sv
module ipe_checker #(
  parameter int NPINS  = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  parameter logic [DEST_W-1:0] BOOT_ID = '0,
  localparam int IDX_W = $clog2(NPINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [VEC_W-1:0]  msg_vector,
  input logic [DEST_W-1:0] msg_dest,
  input logic              msg_dmode,
  input logic [NPINS-1:0]  load_vec,
  input logic [NPINS-1:0]  mask,
  input logic              busy,
  input logic              ack_valid,
  input logic [IDX_W-1:0]  scan_idx
);
  // R6: a held message keeps its contents
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

  // R6: at most one pin is loaded per cycle
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));

  // R5: a masked pin is never loaded
  a_r5_no_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_vec & mask) == '0);

  // R7: pin 0 always goes to the boot processor in physical mode
  a_r7_pin0_override: assert property (@(posedge clk) disable iff (!rst_n)
    load_vec[0] |=> msg_dest == BOOT_ID && msg_dmode == 1'b0);

  // R9: acknowledges only during a scan
  a_r9_ack_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> busy);

  // R9: a scan ends only after the last entry
  a_r9_scan_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(scan_idx) == IDX_W'(NPINS - 1));
endmodule

bind irq_pin_engine ipe_checker #(
  .NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .BOOT_ID(BOOT_ID)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid_o),
  .msg_ready  (msg_ready_i),
  .msg_vector (msg_vector_o),
  .msg_dest   (msg_dest_o),
  .msg_dmode  (msg_dmode_o),
  .load_vec   (load_vec),
  .mask       (ent_mask_i),
  .busy       (eoi_busy_o),
  .ack_valid  (ack_valid_o),
  .scan_idx   (scan_idx)
);

// File: tb/test_irq_pin_engine.sv
module test_irq_pin_engine;
  localparam int NP = 4;
  localparam logic [7:0] BOOT = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]   pin_raw = '0, pol = '0, mask = '1, trig = '0, dmode = '0;
  logic [NP*8-1:0] vecs = '0, dests = '0;
  logic [NP*3-1:0] dlvs = '0;
  logic            eoi_valid_i = 1'b0, eoi_level_i = 1'b0, msg_ready_i = 1'b0;
  logic [7:0]      eoi_vector_i = '0;
  logic            eoi_busy_o, ack_valid_o, msg_valid_o, msg_dmode_o, msg_trig_o, msg_level_o;
  logic [1:0]      ack_pin_o;
  logic [7:0]      msg_dest_o, msg_vector_o;
  logic [2:0]      msg_dlv_o;
  logic [NP-1:0]   coal_o;

  irq_pin_engine #(.NPINS(NP), .VEC_W(8), .DEST_W(8), .DLV_W(3), .BOOT_ID(BOOT)) i_irq_pin_engine (
    .clk(clk), .rst_n(rst_n), .pin_raw_i(pin_raw), .ent_pol_i(pol), .ent_mask_i(mask),
    .ent_trig_i(trig), .ent_dmode_i(dmode), .ent_vec_i(vecs), .ent_dest_i(dests),
    .ent_dlv_i(dlvs), .eoi_valid_i(eoi_valid_i), .eoi_vector_i(eoi_vector_i),
    .eoi_level_i(eoi_level_i), .eoi_busy_o(eoi_busy_o), .ack_valid_o(ack_valid_o),
    .ack_pin_o(ack_pin_o), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
    .msg_dest_o(msg_dest_o), .msg_vector_o(msg_vector_o), .msg_dmode_o(msg_dmode_o),
    .msg_trig_o(msg_trig_o), .msg_dlv_o(msg_dlv_o), .msg_level_o(msg_level_o),
    .coal_o(coal_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit g_got;
  logic [7:0] g_vec, g_dest;
  logic g_dm, g_trig, g_lvl;
  logic [2:0] g_dlv;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_entry(input int p, input logic [7:0] v, input logic [7:0] d,
                           input logic dm, input logic tr, input logic [2:0] dl,
                           input logic pl, input logic mk);
    vecs[p*8 +: 8] = v; dests[p*8 +: 8] = d; dlvs[p*3 +: 3] = dl;
    dmode[p] = dm; trig[p] = tr; pol[p] = pl; mask[p] = mk;
  endtask

  // wait for one message, take it with a single handshake
  task automatic grab();
    g_got = 0;
    for (int k = 0; k < 12 && !g_got; k++) begin
      @(negedge clk);
      if (msg_valid_o) begin
        g_got = 1; g_vec = msg_vector_o; g_dest = msg_dest_o; g_dm = msg_dmode_o;
        g_trig = msg_trig_o; g_dlv = msg_dlv_o; g_lvl = msg_level_o;
        msg_ready_i = 1'b1;
        @(negedge clk);
        msg_ready_i = 1'b0;
      end
    end
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] v, input logic [7:0] d,
                            input logic dm, input logic tr, input logic [2:0] dl);
    grab();
    chk({tag, " got"}, g_got, 1);
    if (g_got) begin
      chk({tag, " vector"}, g_vec, v);
      chk({tag, " dest"}, g_dest, d);
      chk({tag, " dmode"}, g_dm, dm);
      chk({tag, " trig"}, g_trig, tr);
      chk({tag, " dlv"}, g_dlv, dl);
      chk({tag, " level flag"}, g_lvl, 1);
    end
  endtask

  task automatic expect_none(input string tag);
    grab();
    chk({tag, " no message"}, g_got, 0);
  endtask

  task automatic run_eoi(input logic [7:0] v, input logic lvl, input bit inject,
                         output int nack, output int nbusy, output int pf, output int pl);
    @(negedge clk);
    eoi_valid_i = 1'b1; eoi_vector_i = v; eoi_level_i = lvl;
    @(negedge clk);
    eoi_valid_i = 1'b0;
    nack = 0; nbusy = 0; pf = -1; pl = -1;
    for (int c = 0; c < NP + 4; c++) begin
      #1;
      if (eoi_busy_o) nbusy++;
      if (ack_valid_o) begin
        nack++;
        if (pf < 0) pf = int'(ack_pin_o);
        pl = int'(ack_pin_o);
      end
      if (inject && c == 1) begin eoi_valid_i = 1'b1; eoi_vector_i = 8'h41; end
      else eoi_valid_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R6 reset msg_valid", msg_valid_o, 0);
    chk("R9 reset busy", eoi_busy_o, 0);
    chk("R9 reset ack", ack_valid_o, 0);
    chk("R3 reset coal", coal_o, 0);
  endtask

  // R2 R3 R8: edge pin 2, fields copied, re-rise while waiting is coalesced
  task automatic t_edge();
    @(negedge clk);
    set_entry(2, 8'h32, 8'h33, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0);
    pin_raw[2] = 1'b1;
    repeat (3) @(negedge clk);
    pin_raw[2] = 1'b0;
    @(negedge clk); pin_raw[2] = 1'b1;
    @(negedge clk); pin_raw[2] = 1'b0;
    @(negedge clk); pin_raw[2] = 1'b1;
    #1 chk("R3 edge coalesced pulse", coal_o[2], 1);
    expect_msg("R8 edge fields first", 8'h32, 8'h33, 1'b1, 1'b0, 3'd4);
    expect_msg("R2 edge second rise", 8'h32, 8'h33, 1'b1, 1'b0, 3'd4);
    expect_none("R2 edge held high");
    @(negedge clk); pin_raw[2] = 1'b0; mask[2] = 1'b1;
  endtask

  // R1: active-low pin
  task automatic t_polarity();
    @(negedge clk);
    set_entry(3, 8'h37, 8'h21, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
    pin_raw[3] = 1'b1;
    expect_none("R1 raw high idle with polarity 1");
    @(negedge clk); pin_raw[3] = 1'b0;
    expect_msg("R1 raw low active", 8'h37, 8'h21, 1'b0, 1'b0, 3'd0);
    @(negedge clk); mask[3] = 1'b1; pol[3] = 1'b0;
  endtask

  // R5: masked pin stays silent, also after unmask while held
  task automatic t_mask();
    @(negedge clk);
    set_entry(2, 8'h32, 8'h33, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1);
    pin_raw[2] = 1'b1;
    expect_none("R5 masked rise");
    @(negedge clk); mask[2] = 1'b0;
    expect_none("R5 unmask after rise");
    @(negedge clk); pin_raw[2] = 1'b0; mask[2] = 1'b1;
  endtask

  // R6: simultaneous pins, lowest first
  task automatic t_order();
    @(negedge clk);
    set_entry(2, 8'h52, 8'h02, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
    set_entry(3, 8'h53, 8'h03, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0);
    pin_raw[3:2] = 2'b11;
    expect_msg("R6 first lowest", 8'h52, 8'h02, 1'b0, 1'b0, 3'd1);
    expect_msg("R6 then next", 8'h53, 8'h03, 1'b0, 1'b0, 3'd1);
    @(negedge clk); pin_raw[3:2] = 2'b00; mask[3:2] = 2'b11;
  endtask

  // R7: pin 0 override
  task automatic t_pin0();
    @(negedge clk);
    set_entry(0, 8'h20, 8'h77, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0);
    pin_raw[0] = 1'b1;
    expect_msg("R7 pin0 boot", 8'h20, BOOT, 1'b0, 1'b0, 3'd2);
    @(negedge clk); pin_raw[0] = 1'b0; mask[0] = 1'b1;
  endtask

  // R4 R10: level pin 1
  task automatic t_level();
    int na, nb, pf, pl;
    @(negedge clk);
    set_entry(1, 8'h41, 8'h11, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0);
    pin_raw[1] = 1'b1;
    expect_msg("R4 level first", 8'h41, 8'h11, 1'b1, 1'b1, 3'd1);
    expect_none("R4 level held, remote pending");
    @(negedge clk); pin_raw[1] = 1'b0;
    @(negedge clk); pin_raw[1] = 1'b1;
    #1 chk("R4 level re-rise coalesced", coal_o[1], 1);
    run_eoi(8'h41, 1'b0, 0, na, nb, pf, pl);
    chk("R10 edge EOI acks pin1", pf, 1);
    expect_none("R10 edge EOI keeps remote pending");
    run_eoi(8'h41, 1'b1, 0, na, nb, pf, pl);
    chk("R10 level EOI ack count", na, 1);
    expect_msg("R10 level EOI re-fire", 8'h41, 8'h11, 1'b1, 1'b1, 3'd1);
    @(negedge clk); pin_raw[1] = 1'b0; mask[1] = 1'b1;
  endtask

  // R9: ordered acks, busy length, EOI held off while busy
  task automatic t_scan();
    int na, nb, pf, pl;
    @(negedge clk);
    vecs[2*8 +: 8] = 8'h66; vecs[3*8 +: 8] = 8'h66;
    run_eoi(8'h66, 1'b0, 1, na, nb, pf, pl);
    chk("R9 ack count", na, 2);
    chk("R9 first ack pin", pf, 2);
    chk("R9 last ack pin", pl, 3);
    chk("R9 busy cycles", nb, NP);
    #1 chk("R9 idle after scan", eoi_busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge();
    t_polarity();
    t_mask();
    t_order();
    t_pin0();
    t_level();
    t_scan();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule